// File: doc/BRIEF.md
# Device Error Enable/Flag Register with Chip Error Merge

This block holds the error control state of one on-chip device and merges that device's error indication with the error lines of its neighbours. The device presents up to 32 error event lines. Each line has an enable bit and a sticky flag bit in a single 64-bit register. The enables occupy the low half and the flags occupy the high half, so the enable for source n sits at bit n and its flag sits at bit n+32. Software reaches the register through a simple read/write access port at register address 3. Reading returns both halves. Writing replaces the enables and clears every flag whose bit is written as 1.

The device error output is high whenever any flag is set. A merge stage ORs this output with a parameterised number of peer device error lines. It registers the result as a single chip-level error signal meant for a debug controller. Errors are reported only in this asynchronous way; no response-packet exception signalling is involved.

Top module: `err_report_unit`

## Requirements
- R1: The register answers only at access address 3. A write at any other address changes nothing, and a read at any other address returns zero. `acc_rdata` is combinational from `acc_addr`.
- R2: Bits 31:0 of the register are enable bits. They are plain read/write bits, reset to 0, and a write at address 3 loads them from `acc_wdata[31:0]`.
- R3: Flag bit n+32 becomes 1 at the clock edge where `evt_in[n]` is 1 and enable bit n, as held before that edge, is 1. An event whose enable is 0 leaves its flag unchanged.
- R4: A set flag stays set until software clears it. A write at address 3 clears flag n+32 when `acc_wdata[n+32]` is 1 and leaves it unchanged when that bit is 0.
- R5: If a clear of flag n+32 and an enabled event on source n fall on the same edge, the flag ends up set.
- R6: `dev_err` is the OR of all 32 flag bits. It follows the flag register with no added delay.
- R7: `chip_err` is a register loaded each cycle with the OR of `dev_err` and every `peer_err` line. It lags those inputs by exactly one cycle.
- R8: Synchronous active-high reset clears all enables, all flags and `chip_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NSRC | Error event lines from the device, one per source |
| acc_addr | input | ADDR_W | Register access address |
| acc_wr | input | 1 | Write strobe for the access port |
| acc_wdata | input | 64 | Write data: enables in 31:0, flag-clear mask in 63:32 |
| acc_rdata | output | 64 | Read data: enables in 31:0, flags in 63:32 |
| peer_err | input | NPEER | Error outputs of other devices |
| dev_err | output | 1 | OR of this device's flags |
| chip_err | output | 1 | Registered chip-wide error for the debug controller |

## Verification
A software clear and a new enabled event can land on the same flag in the same cycle. An enable rewrite can also coincide with an event on its own source. The bench provokes both by driving the write strobe and the event line in one cycle. In the first case it expects the flag to survive, because the event wins. In the second case it expects the enable value held before the edge to decide. The bench also sweeps every source under two alternating enable patterns and every combination of peer error lines. It judges the result by reading the register back and by watching `dev_err` and `chip_err` one cycle apart.

// File: rtl/err_pkg.sv
package err_pkg;

    localparam int REG_W  = 64;
    localparam int HALF_W = 32;

    // Decoded register access, one per cycle.
    typedef struct packed {
        logic              hit;      // write strobe at the register's address
        logic [HALF_W-1:0] en_data;  // new enable bits
        logic [HALF_W-1:0] clr_mask; // flags to clear (write-one-to-clear)
    } err_wr_t;

    function automatic logic [REG_W-1:0] err_pack(input logic [HALF_W-1:0] flags,
                                                    input logic [HALF_W-1:0] enables);
        return {flags, enables};
    endfunction

endpackage

// File: rtl/err_access_decode.sv
module err_access_decode
    import err_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int REG_ADDR = 3
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic [REG_W-1:0]  acc_wdata,
    input  logic [HALF_W-1:0] en_view,
    input  logic [HALF_W-1:0] flag_view,
    output err_wr_t           wr_cmd,
    output logic [REG_W-1:0]  acc_rdata
);

    localparam logic [ADDR_W-1:0] MatchAddr = ADDR_W'(REG_ADDR);

    logic addr_hit;

    always_comb begin
        addr_hit        = (acc_addr == MatchAddr);
        wr_cmd.hit      = addr_hit & acc_wr;
        wr_cmd.en_data  = acc_wdata[HALF_W-1:0];
        wr_cmd.clr_mask = acc_wdata[REG_W-1:HALF_W];
        acc_rdata       = addr_hit ? err_pack(flag_view, en_view) : '0;
    end

    // R1: a strobe away from the register address never becomes a write
    always_comb begin
        if (acc_wr && (acc_addr != MatchAddr))
            a_foreign_wr_r1: assert (!wr_cmd.hit);
    end

endmodule

// File: rtl/err_flag_bank.sv
module err_flag_bank
    import err_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  err_wr_t           wr_cmd,
    input  logic [NSRC-1:0]   evt_in,
    output logic [HALF_W-1:0] en_q,
    output logic [HALF_W-1:0] flag_q,
    output logic              dev_err
);

    // Enable half: plain read/write storage.
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_cmd.hit)
            en_q <= wr_cmd.en_data;
    end

    // Flag half: one sticky cell per source, unused sources tied low.
    for (genvar i = 0; i < HALF_W; i++) begin : g_cell
        if (i < NSRC) begin : g_live
            logic set_now;
            logic clr_now;

            always_comb begin
                set_now = evt_in[i] & en_q[i];
                clr_now = wr_cmd.hit & wr_cmd.clr_mask[i];
            end

            always_ff @(posedge clk) begin
                if (rst)
                    flag_q[i] <= 1'b0;
                else if (set_now)
                    flag_q[i] <= 1'b1;   // event beats a same-cycle clear
                else if (clr_now)
                    flag_q[i] <= 1'b0;
            end

            p_event_sets_r3: assert property (@(posedge clk) disable iff (rst)
                $past(evt_in[i] && en_q[i]) |-> flag_q[i]);

            p_no_stray_set_r3: assert property (@(posedge clk) disable iff (rst)
                (!$past(flag_q[i]) && !$past(evt_in[i] && en_q[i])) |-> !flag_q[i]);

            p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
                ($past(flag_q[i]) && !$past(wr_cmd.hit && wr_cmd.clr_mask[i])) |-> flag_q[i]);

            p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
                $past(wr_cmd.hit && wr_cmd.clr_mask[i] && evt_in[i] && en_q[i]) |-> flag_q[i]);
        end else begin : g_idle
            always_ff @(posedge clk) flag_q[i] <= 1'b0;
        end
    end

    assign dev_err = |flag_q;

    p_enable_load_r2: assert property (@(posedge clk) disable iff (rst)
        $past(wr_cmd.hit) |-> (en_q == $past(wr_cmd.en_data)));

    p_enable_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_cmd.hit) |-> $stable(en_q));

endmodule

// File: rtl/err_merge.sv
module err_merge #(
    parameter int NIN = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NIN-1:0] err_in,
    output logic           chip_err
);

    always_ff @(posedge clk) begin
        if (rst)
            chip_err <= 1'b0;
        else
            chip_err <= |err_in;
    end

    p_merge_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $past(err_in != '0) |-> chip_err);

    p_merge_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        $past(err_in == '0) |-> !chip_err);

endmodule

// File: rtl/err_report_unit.sv
module err_report_unit
    import err_pkg::*;
#(
    parameter int NSRC     = 32,
    parameter int NPEER    = 3,
    parameter int ADDR_W   = 8,
    parameter int REG_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   evt_in,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic [REG_W-1:0]  acc_wdata,
    output logic [REG_W-1:0]  acc_rdata,
    input  logic [NPEER-1:0]  peer_err,
    output logic              dev_err,
    output logic              chip_err
);

    localparam int NMERGE = NPEER + 1;

    err_wr_t           wr_cmd;
    logic [HALF_W-1:0] en_q;
    logic [HALF_W-1:0] flag_q;

    err_access_decode #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR)
    ) u_decode (
        .acc_addr (acc_addr),
        .acc_wr   (acc_wr),
        .acc_wdata(acc_wdata),
        .en_view  (en_q),
        .flag_view(flag_q),
        .wr_cmd   (wr_cmd),
        .acc_rdata(acc_rdata)
    );

    err_flag_bank #(
        .NSRC(NSRC)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_cmd (wr_cmd),
        .evt_in (evt_in),
        .en_q   (en_q),
        .flag_q (flag_q),
        .dev_err(dev_err)
    );

    err_merge #(
        .NIN(NMERGE)
    ) u_merge (
        .clk     (clk),
        .rst     (rst),
        .err_in  ({peer_err, dev_err}),
        .chip_err(chip_err)
    );

    // R6: whenever the register is visible, dev_err agrees with its flag half
    p_dev_err_view_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_addr == ADDR_W'(REG_ADDR)) |-> (dev_err == (acc_rdata[REG_W-1:HALF_W] != '0)));

    // R8: the cycle after reset leaves everything clear
    p_reset_clear_r8: assert property (@(posedge clk)
        $past(rst) |-> (!chip_err && en_q == '0 && flag_q == '0));

endmodule

// File: tb/err_report_unit_test.sv
`timescale 1ns/1ps
module err_report_unit_test;

    localparam int NSRC  = 32;
    localparam int NPEER = 3;
    localparam int AW    = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NSRC-1:0] evt_in = '0;
    logic [AW-1:0]  acc_addr = 8'd3;
    logic           acc_wr = 1'b0;
    logic [63:0]    acc_wdata = '0;
    logic [63:0]    acc_rdata;
    logic [NPEER-1:0] peer_err = '0;
    logic           dev_err;
    logic           chip_err;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    err_report_unit #(.NSRC(NSRC), .NPEER(NPEER), .ADDR_W(AW), .REG_ADDR(3)) uut (
        .clk(clk), .rst(rst), .evt_in(evt_in), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .peer_err(peer_err),
        .dev_err(dev_err), .chip_err(chip_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock with the given stimulus, then back to idle at address 3.
    task automatic cyc(input logic [AW-1:0] a, input logic w, input logic [63:0] d,
                       input logic [31:0] ev);
        @(negedge clk);
        acc_addr = a; acc_wr = w; acc_wdata = d; evt_in = ev;
        @(negedge clk);
        acc_addr = 8'd3; acc_wr = 1'b0; acc_wdata = '0; evt_in = '0;
        #0.5;
    endtask

    task automatic idle();
        @(negedge clk);
        #0.5;
    endtask

    initial begin
        #(5.0 * 190000);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] en;
        logic [31:0] pat;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R8: reset state
        chk("R8 reg", acc_rdata, 64'h0);
        chk("R8 dev_err", {63'h0, dev_err}, 64'h0);
        chk("R8 chip_err", {63'h0, chip_err}, 64'h0);

        // R2: enable load and readback
        en = 32'hA5A5_5A5A;
        cyc(8'd3, 1'b1, {32'h0, en}, '0);
        chk("R2 enable readback", acc_rdata, {32'h0, en});

        // R1: writes at other addresses ignored, reads there return zero
        for (int a = 0; a < 8; a++) begin
            if (a == 3) continue;
            cyc(AW'(a), 1'b1, 64'hFFFF_FFFF_0000_0000 | 64'(a * 17), '0);
            chk("R1 foreign write ignored", acc_rdata, {32'h0, en});
        end
        @(negedge clk);
        acc_addr = 8'd5;
        #0.5;
        chk("R1 foreign read zero", acc_rdata, 64'h0);
        acc_addr = 8'd3;

        // R3/R6/R7: every source under two alternating enable patterns
        for (int p = 0; p < 2; p++) begin
            en = (p == 0) ? 32'h5555_5555 : 32'hAAAA_AAAA;
            cyc(8'd3, 1'b1, {32'hFFFF_FFFF, en}, '0);
            idle();
            for (int n = 0; n < 32; n++) begin
                logic [31:0] expf;
                expf = en[n] ? (32'h1 << n) : 32'h0;
                cyc(8'd3, 1'b0, '0, 32'h1 << n);
                chk("R3 flag after event", acc_rdata, {expf, en});
                chk("R6 dev_err", {63'h0, dev_err}, {63'h0, (expf != 0)});
                idle();
                chk("R7 chip_err lag", {63'h0, chip_err}, {63'h0, (expf != 0)});
                cyc(8'd3, 1'b1, {32'hFFFF_FFFF, en}, '0);
                idle();
            end
        end

        // R3: mixed event and enable patterns
        for (int k = 1; k < 9; k++) begin
            en  = 32'h9E37_79B9 * k;
            pat = 32'h7F4A_7C15 * (k + 3);
            cyc(8'd3, 1'b1, {32'hFFFF_FFFF, en}, '0);
            cyc(8'd3, 1'b0, '0, pat);
            chk("R3 mixed pattern", acc_rdata, {pat & en, en});
        end

        // R4: stickiness and write-one-to-clear
        en = 32'hFFFF_FFFF;
        cyc(8'd3, 1'b1, {32'hFFFF_FFFF, en}, '0);
        cyc(8'd3, 1'b0, '0, 32'h8);
        repeat (3) idle();
        chk("R4 flag held", acc_rdata, {32'h8, en});
        cyc(8'd3, 1'b1, {32'h0, en}, '0);
        chk("R4 write zero keeps flag", acc_rdata, {32'h8, en});
        cyc(8'd3, 1'b1, {32'h10, en}, '0);
        chk("R4 clear other bit keeps flag", acc_rdata, {32'h8, en});
        cyc(8'd3, 1'b1, {32'h8, en}, '0);
        chk("R4 clear flag", acc_rdata, {32'h0, en});
        chk("R6 dev_err low after clear", {63'h0, dev_err}, 64'h0);

        // R5: clear and event in the same cycle
        cyc(8'd3, 1'b0, '0, 32'h80);
        cyc(8'd3, 1'b1, {32'h0000_0180, en}, 32'h0000_0180);
        chk("R5 event beats clear", acc_rdata, {32'h0000_0180, en});

        // R3: enable rewrite in the same cycle as an event uses the old enable
        cyc(8'd3, 1'b1, {32'hFFFF_FFFF, en}, '0);
        cyc(8'd3, 1'b1, {32'h0, 32'h0}, 32'h4);
        chk("R3 old enable decides set", acc_rdata, {32'h4, 32'h0});
        cyc(8'd3, 1'b1, {32'hFFFF_FFFF, 32'h4}, 32'h0);
        cyc(8'd3, 1'b1, {32'h0, 32'h0}, 32'h3);
        chk("R3 old zero enable blocks set", acc_rdata, 64'h0);

        // R7: every peer combination with flags clear
        idle();
        for (int v = 0; v < (1 << NPEER); v++) begin
            @(negedge clk);
            peer_err = NPEER'(v);
            idle();
            chk("R7 peer merge", {63'h0, chip_err}, {63'h0, (v != 0)});
            chk("R6 dev_err unaffected by peers", {63'h0, dev_err}, 64'h0);
        end
        @(negedge clk);
        peer_err = '0;
        idle();

        // R8: reset clears set state
        cyc(8'd3, 1'b1, {32'h0, 32'hFFFF_FFFF}, '0);
        cyc(8'd3, 1'b0, '0, 32'hF0F0_0001);
        idle();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        chk("R8 reg after reset", acc_rdata, 64'h0);
        chk("R8 chip_err after reset", {63'h0, chip_err}, 64'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule